// File: doc/BRIEF.md
# Two-Level Lookup Logic Cell

This block is one programmable logic cell of the kind tiled across an island-style fabric. Two 4-input lookup tables, called F and G, each compute any Boolean function of their own four inputs. A third 3-input table, called H, combines the F result, the G result and one selectable control line. Output multiplexers steer these results to two combinational outputs and to the data inputs of two flip-flops. With F and G fed the same four signals, a control line acts as the fifth input, so the cell can produce any 5-input function. With different signals on F and G, it gives two independent 4-input functions, or some functions of up to nine inputs.

Every table entry and every select lives in a 58-bit configuration register. The register is filled serially through a one-bit port while a load strobe is high. While loading is in progress both flip-flops keep their state. Once the strobe drops, the configuration stays fixed and the cell evaluates its eight function inputs and four control inputs. The four control lines can serve as the H table's third input, a flip-flop clock enable, a flip-flop set/reset, and a direct flip-flop data input.

Top module: `clb_cell`

## Requirements
- R1: While rst_ni is low, the configuration register and both flip-flops are cleared. After reset, x_o, y_o, xq_o and yq_o are all 0.
- R2: On each rising clock edge with cfg_en_i high, the configuration register shifts left by one bit and cfg_din_i enters bit 0, so the first bit sent ends in bit 57. From bit 57 down to bit 0 the fields are: F table [57:42], G table [41:26], H table [25:18], H control select [17:16], X route [15], Y route [14], XQ data select [13:12], YQ data select [11:10], direct-data control select [9:8], enable use [7], enable control select [6:5], set/reset use [4], set/reset control select [3:2], XQ set/reset value [1], YQ set/reset value [0]. With cfg_en_i low, the register does not change.
- R3: Entry i of the F table is the F output when f_i equals i, with f_i[0] as the least significant bit. The G table follows the same rule with g_i.
- R4: The H table is indexed by {c_i[hsel], G, F}, where F is bit 0 and hsel is the H control select field.
- R5: x_o is F when the X route bit is 0 and H when it is 1. y_o is G when the Y route bit is 0 and H when it is 1. Both outputs are combinational.
- R6: The data select of each flip-flop picks its input: 0 selects F, 1 selects G, 2 selects H, 3 selects c_i[direct-data select]. The flip-flop takes that value on the rising edge.
- R7: When the enable use bit is 1, a flip-flop loads only in cycles where c_i[enable select] is 1. When the enable use bit is 0, the flip-flops load on every edge.
- R8: When the set/reset use bit is 1 and c_i[set/reset select] is 1, each flip-flop takes its set/reset value on the next edge. This overrides both the enable and the data.
- R9: While cfg_en_i is high, xq_o and yq_o hold their values, even when set/reset or enable lines are active.
- R10: With F and G fed the same inputs and H configured as a 2:1 select by its control line, x_o reproduces an arbitrary 32-entry truth table over {c, f}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Configuration shift strobe |
| cfg_din_i | input | 1 | Serial configuration bit |
| f_i | input | 4 | F table inputs |
| g_i | input | 4 | G table inputs |
| c_i | input | 4 | Control inputs |
| x_o | output | 1 | Combinational X output |
| y_o | output | 1 | Combinational Y output |
| xq_o | output | 1 | Registered X flip-flop output |
| yq_o | output | 1 | Registered Y flip-flop output |

## Verification
The table outputs x_o and y_o are combinational, so they are due in the same cycle as the input change. The bench applies the inputs, waits one time unit away from any edge, and compares. xq_o and yq_o change on the first rising edge after their data, enable or set/reset inputs settle. The bench therefore drives each stimulus just after an edge and checks these outputs one time unit after the following edge. A configuration word takes 58 shift edges to load. The bench checks the flip-flop hold after every one of those edges, and checks the new configuration only after the strobe has dropped.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int LUT_K   = 4;
  localparam int COMB_K  = 3;
  localparam int NUM_C   = 4;
  localparam int CSEL_W  = $clog2(NUM_C);
  localparam int NUM_FF  = 2;

  typedef enum logic [1:0] {
    DSEL_F = 2'd0,
    DSEL_G = 2'd1,
    DSEL_H = 2'd2,
    DSEL_C = 2'd3
  } dsel_e;

  typedef struct packed {
    logic [2**LUT_K-1:0]  lut_f;
    logic [2**LUT_K-1:0]  lut_g;
    logic [2**COMB_K-1:0] lut_h;
    logic [CSEL_W-1:0]    h_csel;
    logic                 x_route;
    logic                 y_route;
    dsel_e                dx_sel;
    dsel_e                dy_sel;
    logic [CSEL_W-1:0]    din_csel;
    logic                 ce_use;
    logic [CSEL_W-1:0]    ce_csel;
    logic                 sr_use;
    logic [CSEL_W-1:0]    sr_csel;
    logic                 srval_x;
    logic                 srval_y;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], din_i};
  end
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter int K = 4
) (
  input  logic [2**K-1:0] tbl_i,
  input  logic [K-1:0]    in_i,
  output logic            out_o
);
  assign out_o = tbl_i[in_i];
endmodule

// File: rtl/clb_ff.sv
module clb_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ce_i,
  input  logic sr_i,
  input  logic srval_i,
  input  logic d_i,
  output logic q_o
);
  // set/reset outranks enable; config load freezes everything
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (!hold_i) begin
      if (sr_i)        q_o <= srval_i;
      else if (ce_i)   q_o <= d_i;
    end
  end
endmodule

// File: rtl/clb_cell.sv
module clb_cell
  import clb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_din_i,
  input  logic [LUT_K-1:0] f_i,
  input  logic [LUT_K-1:0] g_i,
  input  logic [NUM_C-1:0] c_i,
  output logic             x_o,
  output logic             y_o,
  output logic             xq_o,
  output logic             yq_o
);
  logic [CFG_W-1:0] cfg_q;
  cfg_t             cfg;
  logic             f_out, g_out, h_out;
  logic [COMB_K-1:0] h_in;
  logic             din_c, ce, sr;
  dsel_e            dsel [NUM_FF];
  logic [NUM_FF-1:0] srval, dval, q;

  clb_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .din_i (cfg_din_i),
    .q_o   (cfg_q)
  );

  assign cfg = cfg_t'(cfg_q);

  clb_lut #(.K(LUT_K)) u_lut_f (.tbl_i(cfg.lut_f), .in_i(f_i), .out_o(f_out));
  clb_lut #(.K(LUT_K)) u_lut_g (.tbl_i(cfg.lut_g), .in_i(g_i), .out_o(g_out));

  assign h_in = {c_i[cfg.h_csel], g_out, f_out};
  clb_lut #(.K(COMB_K)) u_lut_h (.tbl_i(cfg.lut_h), .in_i(h_in), .out_o(h_out));

  assign x_o = cfg.x_route ? h_out : f_out;
  assign y_o = cfg.y_route ? h_out : g_out;

  assign din_c = c_i[cfg.din_csel];
  assign ce    = !cfg.ce_use || c_i[cfg.ce_csel];
  assign sr    = cfg.sr_use && c_i[cfg.sr_csel];

  assign dsel[0] = cfg.dx_sel;
  assign dsel[1] = cfg.dy_sel;
  assign srval   = {cfg.srval_y, cfg.srval_x};

  for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
    always_comb begin
      unique case (dsel[i])
        DSEL_F:  dval[i] = f_out;
        DSEL_G:  dval[i] = g_out;
        DSEL_H:  dval[i] = h_out;
        default: dval[i] = din_c;
      endcase
    end

    clb_ff u_ff (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (cfg_en_i),
      .ce_i   (ce),
      .sr_i   (sr),
      .srval_i(srval[i]),
      .d_i    (dval[i]),
      .q_o    (q[i])
    );
  end

  assign xq_o = q[0];
  assign yq_o = q[1];
endmodule

// File: rtl/clb_cell_chk.sv
module clb_cell_chk
  import clb_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_en_i,
  input logic                 cfg_din_i,
  input logic [LUT_K-1:0]     f_i,
  input logic [NUM_C-1:0]     c_i,
  input logic                 x_o,
  input logic                 xq_o,
  input logic                 yq_o,
  input logic [CFG_W-1:0]     cfg_q
);
  cfg_t cfg;
  assign cfg = cfg_t'(cfg_q);

  // R2
  cfg_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_din_i)});

  // R2
  cfg_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_q));

  // R9
  ff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> $stable(xq_o) && $stable(yq_o));

  // R8
  sr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && cfg.sr_use && c_i[cfg.sr_csel])
      |=> (xq_o == $past(cfg.srval_x)) && (yq_o == $past(cfg.srval_y)));

  // R7
  ce_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && cfg.ce_use && !c_i[cfg.ce_csel] && !(cfg.sr_use && c_i[cfg.sr_csel]))
      |=> $stable(xq_o) && $stable(yq_o));

  // R5
  x_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.x_route |-> x_o == cfg.lut_f[f_i]);
endmodule

bind clb_cell clb_cell_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_en_i (cfg_en_i),
  .cfg_din_i(cfg_din_i),
  .f_i      (f_i),
  .c_i      (c_i),
  .x_o      (x_o),
  .xq_o     (xq_o),
  .yq_o     (yq_o),
  .cfg_q    (cfg_q)
);

// File: tb/tb_clb_cell.sv
module tb_clb_cell;
  localparam int W = 58;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_en_i = 1'b0;
  logic       cfg_din_i = 1'b0;
  logic [3:0] f_i = '0, g_i = '0, c_i = '0;
  logic       x_o, y_o, xq_o, yq_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  clb_cell dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk(
      input logic [15:0] lf, input logic [15:0] lg, input logic [7:0] lh,
      input logic [1:0] hc, input logic xr, input logic yr,
      input logic [1:0] dx, input logic [1:0] dy, input logic [1:0] dc,
      input logic ceu, input logic [1:0] cec, input logic sru,
      input logic [1:0] src, input logic srx, input logic sry);
    return {lf, lg, lh, hc, xr, yr, dx, dy, dc, ceu, cec, sru, src, srx, sry};
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // R2: MSB first, one bit per edge; optional hold check after every edge (R9)
  task automatic load(input logic [W-1:0] v, input logic chk_hold);
    logic hx, hy;
    logic bad;
    hx = xq_o; hy = yq_o; bad = 1'b0;
    cfg_en_i = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      cfg_din_i = v[i];
      tick();
      if (xq_o !== hx || yq_o !== hy) bad = 1'b1;
    end
    cfg_en_i = 1'b0;
    if (chk_hold) chk("R9 hold during load", bad, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 x_o", x_o, 1'b0);
    chk("R1 y_o", y_o, 1'b0);
    chk("R1 xq_o", xq_o, 1'b0);
    chk("R1 yq_o", yq_o, 1'b0);
  endtask

  task automatic t_lut_fg();
    logic [15:0] tf, tg;
    tf = 16'hA5C3; tg = 16'h1234;
    load(mk(tf, tg, 8'h00, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0), 1'b0);
    for (int i = 0; i < 16; i++) begin
      f_i = i[3:0]; g_i = 4'(15 - i);
      #1;
      chk("R3 R2 F table", x_o, tf[i]);
      chk("R3 G table", y_o, tg[15 - i]);
    end
  endtask

  task automatic t_five_input();
    logic [31:0] tt;
    tt = 32'hE8A1_7F30;
    // H = c ? G : F on index {c,g,f}
    load(mk(tt[15:0], tt[31:16], 8'hCA, 2'd2, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0), 1'b0);
    for (int i = 0; i < 32; i++) begin
      f_i = i[3:0]; g_i = i[3:0];
      c_i = {1'b0, i[4], 1'b0, ~i[4]};
      #1;
      chk("R10 R4 5-input x_o", x_o, tt[i]);
      chk("R5 y_o via H", y_o, tt[i]);
    end
    c_i = '0;
  endtask

  task automatic t_ff_paths();
    // XQ <- c[1] direct, YQ <- F (AND)
    load(mk(16'h8000, 16'h0000, 8'h00, 2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0), 1'b0);
    f_i = 4'hF; c_i = 4'b0010; tick();
    chk("R6 XQ direct 1", xq_o, 1'b1);
    chk("R6 YQ from F 1", yq_o, 1'b1);
    f_i = 4'h0; c_i = 4'b0000; tick();
    chk("R6 XQ direct 0", xq_o, 1'b0);
    chk("R6 YQ from F 0", yq_o, 1'b0);
    // XQ <- H (= c[0]), YQ <- G (NOR)
    load(mk(16'h0000, 16'h0001, 8'hF0, 2'd0, 1'b0, 1'b0, 2'd2, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0), 1'b0);
    g_i = 4'h0; c_i = 4'b0001; tick();
    chk("R6 XQ from H 1", xq_o, 1'b1);
    chk("R6 YQ from G 1", yq_o, 1'b1);
    g_i = 4'h1; c_i = 4'b0000; tick();
    chk("R6 XQ from H 0", xq_o, 1'b0);
    chk("R6 YQ from G 0", yq_o, 1'b0);
  endtask

  task automatic t_enable();
    // both <- c[0], enable = c[3]
    load(mk(16'h0, 16'h0, 8'h0, 2'd0, 1'b0, 1'b0, 2'd3, 2'd3, 2'd0, 1'b1, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0), 1'b0);
    c_i = 4'b0001; tick();
    chk("R7 blocked load", xq_o, 1'b0);
    c_i = 4'b1001; tick();
    chk("R7 enabled load", xq_o, 1'b1);
    c_i = 4'b0000; tick();
    chk("R7 held when disabled", yq_o, 1'b1);
  endtask

  task automatic t_set_reset();
    // sr = c[2], values X=1 Y=0, enable = c[3], data = c[0]
    load(mk(16'h0, 16'h0, 8'h0, 2'd0, 1'b0, 1'b0, 2'd3, 2'd3, 2'd0, 1'b1, 2'd3, 1'b1, 2'd2, 1'b1, 1'b0), 1'b0);
    c_i = 4'b1001; tick();
    chk("R8 normal X", xq_o, 1'b1);
    chk("R8 normal Y", yq_o, 1'b1);
    c_i = 4'b0101; tick();
    chk("R8 sr over disabled X", xq_o, 1'b1);
    chk("R8 sr over disabled Y", yq_o, 1'b0);
    c_i = 4'b1100; tick();
    chk("R8 sr over enable+data X", xq_o, 1'b1);
    chk("R8 sr over enable+data Y", yq_o, 1'b0);
    c_i = 4'b1000; tick();
    chk("R8 released X", xq_o, 1'b0);
    c_i = 4'b1001; tick();
    chk("R8 reload X", xq_o, 1'b1);
  endtask

  task automatic t_cfg_hold();
    // sr line held high throughout the load of a config that resets to 0
    c_i = 4'b0100;
    load(mk(16'h0, 16'h0, 8'h0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0), 1'b1);
    chk("R9 X kept after load", xq_o, 1'b1);
    chk("R9 Y kept after load", yq_o, 1'b1);
    tick();
    chk("R8 new sr acts X", xq_o, 1'b0);
    chk("R8 new sr acts Y", yq_o, 1'b0);
    c_i = '0;
  endtask

  task automatic t_reset_again();
    // F = 1, Y <- H = 1, XQ <- F
    load(mk(16'hFFFF, 16'h0, 8'hFF, 2'd0, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0), 1'b0);
    tick();
    chk("R1 pre-reset x_o", x_o, 1'b1);
    chk("R1 pre-reset xq_o", xq_o, 1'b1);
    rst_ni = 1'b0; #1;
    chk("R1 x_o cleared", x_o, 1'b0);
    chk("R1 y_o cleared", y_o, 1'b0);
    chk("R1 xq_o cleared", xq_o, 1'b0);
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 config stays clear", x_o, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_lut_fg();
    t_five_input();
    t_ff_paths();
    t_enable();
    t_set_reset();
    t_cfg_hold();
    t_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule